// File: doc/BRIEF.md
# Instruction Cache Line-Fill Controller

This block runs the refills of a direct-mapped instruction cache built from 16-byte lines and a single line-sized fill buffer. When a core fetch misses both the buffer and the array, the controller chooses between fetching the whole line and fetching only the requested longword. The choice depends on a 2-bit fill-mode control and on the longword offset of the miss. It then drives the external longword bus, starting with the requested longword and wrapping around the line. The requested longword goes to the core in the cycle it arrives. Every arriving longword is captured in the fill buffer, and the buffer can serve hits as soon as the needed longword is present.

A most-recently-used flag records whether the buffer or the array holds the newer copy of the buffered line's set. The flag is set by each miss that loads the buffer. It is cleared when the array serves an access to the same set. At the next buffer-loading miss, a complete and still most-recent cacheable line is written into the arrays through a one-cycle, full-line write port. A second control bit lets noncacheable fetches use the buffer as temporary storage. That data is never written into the array.

Top module: `icache_refill_ctrl`

## Requirements
- R1: During a refill, `bus_addr[31:4]` is the miss line and `bus_addr[3:2]` starts at the miss offset (`core_addr[3:2]`), then advances by one modulo 4 after each beat accepted with `bus_ready`.
- R2: A buffer-loading miss fetches 4 beats or 1 beat. `ctl_fill_mode` 2'b00 always fetches the line. 2'b01 fetches the line unless the offset is 3. 2'b10 and 2'b11 fetch the line only at offset 0. A single-beat fetch is one bus transfer.
- R3: While `bus_req` is high and `bus_ready` is low, `bus_req` and `bus_addr` stay unchanged into the next cycle.
- R4: In the cycle the first beat of a refill is accepted, `core_ack` is high and `core_rdata` equals `bus_rdata`.
- R5: A request whose line matches the buffer line and whose longword has arrived is acknowledged in the same cycle with the buffered data. This also holds during a burst, once the first beat has arrived.
- R6: The MRU flag is set by every buffer-loading miss. It is cleared when the array serves a request whose `core_addr[8:4]` equals bits [8:4] of the buffer line.
- R7: On a buffer-loading miss, `arr_wr_en` pulses for that cycle only if the old buffer holds all 4 longwords, its MRU flag is set and its line was cacheable. `arr_wr_line` is the old line, and longword i is at `arr_wr_data[32*i +: 32]`.
- R8: A noncacheable miss (`core_cacheable`=0) with `ctl_nc_buffer`=1 loads the buffer like a cacheable miss and may later hit, but is never written back. With `ctl_nc_buffer`=0 it fetches one longword, ignores `arr_hit`, and leaves the buffer and the MRU flag unchanged.
- R9: While a refill is in progress, misses and array hits are not acknowledged. Only buffer hits are served after the first beat. The cycle in which a miss is detected gives no acknowledge.
- R10: After reset the controller is idle with `bus_req` low, an empty buffer and a clear MRU flag.
- R11: When idle, a cacheable request that misses the buffer but has `arr_hit` high is acknowledged in the same cycle with `arr_rd_data`. A buffer hit takes priority over an array hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_fill_mode | input | 2 | Fill-size mode, sampled at a miss |
| ctl_nc_buffer | input | 1 | Let noncacheable fetches use the fill buffer |
| core_req | input | 1 | Core fetch request, held until acknowledged |
| core_addr | input | ADDR_W-2 | Longword address of the fetch (byte address bits [ADDR_W-1:2]) |
| core_cacheable | input | 1 | Fetch is cacheable |
| core_ack | output | 1 | Request served this cycle |
| core_rdata | output | DATA_W | Fetched longword, valid with core_ack |
| arr_hit | input | 1 | Array tag lookup hit for core_addr |
| arr_rd_data | input | DATA_W | Array read data for core_addr |
| bus_req | output | 1 | External bus transfer request |
| bus_addr | output | ADDR_W | External longword byte address |
| bus_ready | input | 1 | Bus transfer completes this cycle |
| bus_rdata | input | DATA_W | Bus read data |
| arr_wr_en | output | 1 | Write one line into the arrays |
| arr_wr_line | output | ADDR_W-4 | Line address of the write |
| arr_wr_data | output | 4*DATA_W | Line data, longword 0 in the low bits |

## Verification
The bench goes after the wrap of the beat order for each miss offset. A controller that counted up from offset zero, or carried into the line bits, would put the wrong `bus_addr` on the bus. It also tests the full fill-size table in all four modes; a single-beat miss that turned into a burst would keep `bus_req` high for too long. Write-back is stressed after partial lines, after noncacheable buffered lines and after an array access to the same set has cleared the MRU flag. A design that wrote back in any of those cases would show a stray `arr_wr_en`. Buffer hits issued during a burst and stalls of misses behind it are checked too. Serving a longword that has not yet arrived, or accepting a second miss during a burst, would break the acknowledge and data comparisons.

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            ctl_fill_mode,
  input  logic                  ctl_nc_buffer,
  input  logic                  core_req,
  input  logic [ADDR_W-1:2]     core_addr,
  input  logic                  core_cacheable,
  output logic                  core_ack,
  output logic [DATA_W-1:0]     core_rdata,
  input  logic                  arr_hit,
  input  logic [DATA_W-1:0]     arr_rd_data,
  output logic                  bus_req,
  output logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_ready,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  arr_wr_en,
  output logic [ADDR_W-5:0]     arr_wr_line,
  output logic [4*DATA_W-1:0]   arr_wr_data
);
  localparam int LINE_W = ADDR_W - 4;
  localparam int WORDS  = 4;

  logic              busy, f_tobuf;
  logic [1:0]        cnt, last, off;
  logic [LINE_W-1:0] f_line;

  logic [LINE_W-1:0] b_line;
  logic [WORDS-1:0]  b_vld;
  logic [DATA_W-1:0] b_data [WORDS];
  logic              b_mru, b_cach;

  wire [LINE_W-1:0] req_line = core_addr[ADDR_W-1:4];
  wire [1:0]        req_off  = core_addr[3:2];
  wire [1:0]        beat_off = off + cnt;
  wire              crit     = busy && (cnt == 2'd0);

  wire buf_hit   = core_req && (b_line == req_line) && b_vld[req_off];
  wire arr_serve = core_req && !busy && !buf_hit && core_cacheable && arr_hit;
  wire miss      = core_req && !busy && !buf_hit && !arr_serve;
  wire to_buf    = core_cacheable || ctl_nc_buffer;
  wire want_line = to_buf && ((ctl_fill_mode == 2'b00) ||
                              (ctl_fill_mode == 2'b01 && req_off != 2'd3) ||
                              (req_off == 2'd0));
  wire same_set  = req_line[SET_W-1:0] == b_line[SET_W-1:0];
  wire beat      = busy && bus_ready;

  assign core_ack   = busy ? (crit ? (core_req && bus_ready) : buf_hit)
                           : (buf_hit || arr_serve);
  assign core_rdata = crit ? bus_rdata : (buf_hit ? b_data[req_off] : arr_rd_data);

  assign bus_req  = busy;
  assign bus_addr = {f_line, beat_off, 2'b00};

  assign arr_wr_en   = miss && to_buf && (&b_vld) && b_mru && b_cach;
  assign arr_wr_line = b_line;
  for (genvar i = 0; i < WORDS; i++) begin : g_wr
    assign arr_wr_data[i*DATA_W +: DATA_W] = b_data[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= 2'd0;
      last    <= 2'd0;
      off     <= 2'd0;
      f_line  <= '0;
      f_tobuf <= 1'b0;
      b_line  <= '0;
      b_vld   <= '0;
      b_mru   <= 1'b0;
      b_cach  <= 1'b0;
    end else begin
      if (miss) begin
        busy    <= 1'b1;
        cnt     <= 2'd0;
        off     <= req_off;
        f_line  <= req_line;
        f_tobuf <= to_buf;
        last    <= want_line ? 2'd3 : 2'd0;
        if (to_buf) begin
          b_line <= req_line;
          b_vld  <= '0;
          b_mru  <= 1'b1;
          b_cach <= core_cacheable;
        end
      end else if (arr_serve && same_set) begin
        b_mru <= 1'b0;
      end
      if (beat) begin
        if (f_tobuf) b_vld[beat_off] <= 1'b1;
        cnt <= cnt + 2'd1;
        if (cnt == last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat && f_tobuf) b_data[beat_off] <= bus_rdata;
  end

  // R1: each accepted non-final beat moves to the next longword of the same line
  a_r1_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_ready && cnt != last) |=>
      (busy && bus_addr[3:2] == $past(bus_addr[3:2]) + 2'd1 &&
       bus_addr[ADDR_W-1:4] == $past(bus_addr[ADDR_W-1:4])));

  // R3: an unaccepted transfer is held
  a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)));

  // R6: the MRU flag rises only from an idle-cycle request
  a_r6_mru_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_mru) |-> $past(!busy && core_req));

  // R7: a write-back is followed by a fresh, empty, most-recent buffer and a burst
  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |=> (busy && b_mru && b_vld == '0));

  // R9: no second miss starts while busy
  a_r9_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(bus_ready && cnt == last)) |=> (busy && $stable(f_line)));
endmodule

// File: tb/icache_refill_ctrl_bench.sv
module icache_refill_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl_fill_mode = 2'b00;
  logic        ctl_nc_buffer = 1'b0;
  logic        core_req = 1'b0;
  logic [31:2] core_addr = '0;
  logic        core_cacheable = 1'b0;
  logic        core_ack;
  logic [31:0] core_rdata;
  logic        arr_hit = 1'b0;
  logic [31:0] arr_rd_data;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata;
  logic        arr_wr_en;
  logic [27:0] arr_wr_line;
  logic [127:0] arr_wr_data;

  always #10 clk = ~clk;

  function automatic logic [31:0] bus_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction
  function automatic logic [31:0] arr_val(input logic [31:2] a);
    return {2'b00, a} ^ 32'hC0DE_0000;
  endfunction

  assign bus_rdata   = bus_val(bus_addr);
  assign arr_rd_data = arr_val(core_addr);

  icache_refill_ctrl u_icache_refill_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_fill_mode(ctl_fill_mode), .ctl_nc_buffer(ctl_nc_buffer),
    .core_req(core_req), .core_addr(core_addr), .core_cacheable(core_cacheable),
    .core_ack(core_ack), .core_rdata(core_rdata), .arr_hit(arr_hit), .arr_rd_data(arr_rd_data),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .arr_wr_en(arr_wr_en), .arr_wr_line(arr_wr_line), .arr_wr_data(arr_wr_data));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit          m_busy, m_tob, hold_prev, pending;
  int          m_idx, m_total, m_off;
  logic [27:0] m_line, mb_line;
  logic [31:0] mb_d [4];
  bit          mb_v [4];
  bit          mb_mru, mb_cach;
  int unsigned rs = 32'h2468_ACE1;

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit hit, aserve, miss, tob, exp_ack, exp_wr, full, line;
    logic [31:0] exp_data, exp_addr;
    string tag, wtag;
    #2;
    hit    = core_req && mb_line == core_addr[31:4] && mb_v[core_addr[3:2]];
    aserve = !m_busy && core_req && core_cacheable && arr_hit && !hit;
    miss   = !m_busy && core_req && !hit && !aserve;
    tob    = core_cacheable || ctl_nc_buffer;
    full   = mb_v[0] && mb_v[1] && mb_v[2] && mb_v[3];
    exp_addr = {m_line, 2'(m_off + m_idx), 2'b00};
    exp_data = '0;
    if (m_busy) begin
      if (m_idx == 0) begin
        exp_ack = core_req && bus_ready; exp_data = bus_val(exp_addr); tag = "R4";
      end else begin
        exp_ack = hit; exp_data = mb_d[core_addr[3:2]]; tag = hit ? "R5" : "R9";
      end
    end else if (hit) begin
      exp_ack = 1; exp_data = mb_d[core_addr[3:2]]; tag = mb_cach ? "R5" : "R8";
    end else if (aserve) begin
      exp_ack = 1; exp_data = arr_val(core_addr); tag = "R11";
    end else begin
      exp_ack = 0; tag = core_cacheable ? "R9" : "R8";
    end
    exp_wr = miss && tob && full && mb_mru && mb_cach;
    wtag = (miss && tob && full && !mb_mru && mb_cach) ? "R6" :
           (miss && tob && full && !mb_cach) ? "R8" : "R7";

    chk(tag, "core_ack", 128'(core_ack), 128'(exp_ack));
    if (exp_ack) chk(tag, "core_rdata", 128'(core_rdata), 128'(exp_data));
    chk("R2", "bus_req", 128'(bus_req), 128'(m_busy));
    if (m_busy) chk(hold_prev ? "R3" : "R1", "bus_addr", 128'(bus_addr), 128'(exp_addr));
    chk(wtag, "arr_wr_en", 128'(arr_wr_en), 128'(exp_wr));
    if (exp_wr) begin
      chk("R7", "arr_wr_line", 128'(arr_wr_line), 128'(mb_line));
      chk("R7", "arr_wr_data", arr_wr_data, {mb_d[3], mb_d[2], mb_d[1], mb_d[0]});
    end

    hold_prev = m_busy && !bus_ready;
    if (m_busy) begin
      if (bus_ready) begin
        if (m_tob) begin
          mb_v[(m_off + m_idx) % 4] = 1;
          mb_d[(m_off + m_idx) % 4] = bus_val(exp_addr);
        end
        m_idx++;
        if (m_idx == m_total) m_busy = 0;
      end
    end else if (miss) begin
      m_off = int'(core_addr[3:2]);
      line = tob && (ctl_fill_mode == 2'b00 ? 1'b1 :
                     ctl_fill_mode == 2'b01 ? (m_off != 3) : (m_off == 0));
      m_total = line ? 4 : 1;
      m_busy = 1; m_idx = 0; m_tob = tob; m_line = core_addr[31:4];
      if (tob) begin
        mb_line = core_addr[31:4];
        for (int i = 0; i < 4; i++) mb_v[i] = 0;
        mb_mru = 1; mb_cach = core_cacheable;
      end
    end else if (aserve && core_addr[8:4] == mb_line[4:0]) begin
      mb_mru = 0;
    end
    if (exp_ack) pending = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_busy = 0; hold_prev = 0; pending = 0; mb_line = '0; mb_mru = 0; mb_cach = 0;
    m_line = '0; m_off = 0; m_idx = 0; m_total = 1; m_tob = 0;
    for (int i = 0; i < 4; i++) begin mb_v[i] = 0; mb_d[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: idle after reset
    #2;
    chk("R10", "bus_req after reset", 128'(bus_req), 128'(0));
    chk("R10", "core_ack after reset", 128'(core_ack), 128'(0));
    chk("R10", "arr_wr_en after reset", 128'(arr_wr_en), 128'(0));
    @(negedge clk);
    // R10: first miss must not write back (buffer empty, MRU clear)
    core_req = 1; core_addr = 30'h40; core_cacheable = 1; arr_hit = 0; bus_ready = 1;
    pending = 1;
    while (pending) step();
    for (int phase = 0; phase < 8; phase++) begin
      ctl_fill_mode = 2'(phase % 4);
      ctl_nc_buffer = phase >= 4;
      for (int c = 0; c < 2000; c++) begin
        if (!pending) begin
          if (rnd() % 5 != 0) begin
            pending = 1;
            core_req = 1;
            core_addr = {19'(rnd() % 3), 5'(rnd() % 3), 4'(rnd() % 4)} >> 0;
            core_addr = {2'b00, core_addr[31:4], 2'(rnd() % 4)};
            core_cacheable = (rnd() % 4) != 0;
            arr_hit = (rnd() % 3) == 0;
          end else begin
            core_req = 0; arr_hit = 0;
          end
        end
        bus_ready = (rnd() % 3) != 0;
        step();
      end
    end
    core_req = 0;
    repeat (10) step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule